// File: doc/BRIEF.md
# Configurable GPIO port with edge interrupts

This block is a seven-pin general-purpose I/O port that a small processor core reaches over a byte-wide register bus. Each pin has its own mode: plain input, input with pull-up, push-pull output, or open-drain output. The block drives per-pin output-enable, output-value and pull-up-enable signals toward the pad cells. It samples the pad levels through a multi-flop synchroniser. It also raises an active-low interrupt request when a selected edge is seen on an enabled pin.

Each pin has an interrupt enable, an edge choice (rising or falling) and a sticky pending flag. Hardware sets the flag. Software clears it by writing a zero to it. The request line stays low while any flag is set. Software can poll the pending register, or service the request line and then clear the flags.

The register bus is a plain single-cycle control path with no back-pressure. A write lands on the rising clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the address. The block has no streaming data path, so no valid/ready handshake is needed.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset all configuration, enable, edge, latch and pending registers are zero: `pad_oe`, `pad_out` and `pad_pu` are all 0, `irq_n` is 1 and every register reads 0x00.
- R2: The register map is as follows. 0xE4 is the data register (bits 6:0). 0xE6 configures pins 0–3 (pin k at bits 2k+1:2k). 0xE5 configures pins 4–6 (pin 4+k at bits 2k+1:2k, bits 7:6 read 0). 0xEC is interrupt enable and 0xD6 is pending (bit n = pin n, bit 7 reads 0). 0xEE selects edges for pins 0–3 (bits 3:0, bits 7:4 read 0) and 0xED for pins 4–6 (bits 2:0, bits 7:3 read 0). Any other address, or `bus_sel` low, reads 0x00.
- R3: The 2-bit mode code sets the pad pins as follows. 00 gives input (oe=0, pu=0). 01 gives input with pull-up (oe=0, pu=1). 10 gives push-pull (oe=1, out=latch bit, pu=0). The pull-up is never on while the pin drives.
- R4: Mode code 11 is open-drain. With latch bit 0 it drives low (oe=1, out=0). With latch bit 1 the driver is off (oe=0). An open-drain pin never drives high.
- R5: Reading the data register returns the synchronised pad levels, not the latches. A pad change applied before clock edge k is visible from just after edge k+1.
- R6: With a pin's enable bit at 1, an edge-select bit of 1 sets its pending flag on a rising edge of the synchronised level. An edge-select bit of 0 sets it on a falling edge. The flag is visible just after edge k+2 for a pad change applied before edge k.
- R7: An edge on a pin whose enable bit is 0 never sets its pending flag.
- R8: `irq_n` is 0 exactly while at least one pending flag is 1.
- R9: Writing 0 to a pending bit clears it. Writing 1 leaves it unchanged.
- R10: If a pending set and a clearing write to the same bit land on the same clock edge, the bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| pad_in | input | 7 | Pad input levels (asynchronous) |
| pad_oe | output | 7 | Per-pin driver enable |
| pad_out | output | 7 | Per-pin driven value |
| pad_pu | output | 7 | Per-pin pull-up enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: seven pins split four low and three high, and a two-stage synchroniser. This makes the high configuration and edge registers only partly populated, so their unused read bits can be probed. It also makes the exact two-edge readback and three-edge pending latency observable. A behavioural reference model keeps a queue of sampled pad values with one entry per synchroniser stage plus one. It is compared with the pad controls and the request line on every clock. A set-versus-clear collision is staged on the exact edge where both land.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_IN    = 2'b00,
    PM_IN_PU = 2'b01,
    PM_PUSH  = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  localparam logic [7:0] ADR_DATA    = 8'hE4;
  localparam logic [7:0] ADR_CFG_HI  = 8'hE5;
  localparam logic [7:0] ADR_CFG_LO  = 8'hE6;
  localparam logic [7:0] ADR_IE      = 8'hEC;
  localparam logic [7:0] ADR_EDGE_HI = 8'hED;
  localparam logic [7:0] ADR_EDGE_LO = 8'hEE;
  localparam logic [7:0] ADR_PEND    = 8'hD6;

endpackage

// File: rtl/gpio_port_sync.sv
// Multi-stage synchroniser with level-change detection per pin.
module gpio_port_sync #(
  parameter int NPINS  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);

  logic [NPINS-1:0] stg_q [STAGES];
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pad_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/gpio_port_pads.sv
// Mode decode toward the pad cells.
module gpio_port_pads
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pin_mode_e [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]      latch_i,
  output logic [NPINS-1:0]      pad_oe,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_pu
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic oe_l, out_l, pu_l;
    always_comb begin
      oe_l  = 1'b0;
      out_l = 1'b0;
      pu_l  = 1'b0;
      case (mode_i[i])
        PM_IN_PU: pu_l = 1'b1;
        PM_PUSH: begin
          oe_l  = 1'b1;
          out_l = latch_i[i];
        end
        PM_OPEN: oe_l = ~latch_i[i];
        default: ;
      endcase
    end
    assign pad_oe[i]  = oe_l;
    assign pad_out[i] = out_l;
    assign pad_pu[i]  = pu_l;
  end

  // R3
  pu_with_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  // R4
  drive_high_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & ~latch_i) == '0);

endmodule

// File: rtl/gpio_port_regs.sv
// Register file, read mux and pending-flag handling.
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS   = 7,
  parameter int LO_PINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [NPINS-1:0]      level_i,
  input  logic [NPINS-1:0]      rise_i,
  input  logic [NPINS-1:0]      fall_i,
  output pin_mode_e [NPINS-1:0] mode_o,
  output logic [NPINS-1:0]      latch_o,
  output logic [NPINS-1:0]      pend_o
);

  localparam int HI_PINS = NPINS - LO_PINS;
  localparam int LO_CW   = 2 * LO_PINS;
  localparam int HI_CW   = 2 * HI_PINS;

  logic [LO_CW-1:0]   cfg_lo_q;
  logic [HI_CW-1:0]   cfg_hi_q;
  logic [LO_PINS-1:0] edge_lo_q;
  logic [HI_PINS-1:0] edge_hi_q;
  logic [NPINS-1:0]   ie_q, pend_q, latch_q;
  logic [NPINS-1:0]   edge_sel, set_vec;

  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  logic hit_data, hit_clo, hit_chi, hit_ie, hit_elo, hit_ehi, hit_pend;
  assign hit_data = wr_en && (bus_addr == ADR_DATA);
  assign hit_clo  = wr_en && (bus_addr == ADR_CFG_LO);
  assign hit_chi  = wr_en && (bus_addr == ADR_CFG_HI);
  assign hit_ie   = wr_en && (bus_addr == ADR_IE);
  assign hit_elo  = wr_en && (bus_addr == ADR_EDGE_LO);
  assign hit_ehi  = wr_en && (bus_addr == ADR_EDGE_HI);
  assign hit_pend = wr_en && (bus_addr == ADR_PEND);

  assign edge_sel = {edge_hi_q, edge_lo_q};
  assign set_vec  = ie_q & ((edge_sel & rise_i) | (~edge_sel & fall_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lo_q  <= '0;
      cfg_hi_q  <= '0;
      edge_lo_q <= '0;
      edge_hi_q <= '0;
      ie_q      <= '0;
      latch_q   <= '0;
      pend_q    <= '0;
    end else begin
      if (hit_clo)  cfg_lo_q  <= bus_wdata[LO_CW-1:0];
      if (hit_chi)  cfg_hi_q  <= bus_wdata[HI_CW-1:0];
      if (hit_elo)  edge_lo_q <= bus_wdata[LO_PINS-1:0];
      if (hit_ehi)  edge_hi_q <= bus_wdata[HI_PINS-1:0];
      if (hit_ie)   ie_q      <= bus_wdata[NPINS-1:0];
      if (hit_data) latch_q   <= bus_wdata[NPINS-1:0];
      // set has priority over a same-edge clear
      pend_q <= (hit_pend ? (pend_q & bus_wdata[NPINS-1:0]) : pend_q) | set_vec;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_mode
    if (i < LO_PINS) begin : g_lo
      assign mode_o[i] = pin_mode_e'(cfg_lo_q[2*i +: 2]);
    end else begin : g_hi
      assign mode_o[i] = pin_mode_e'(cfg_hi_q[2*(i-LO_PINS) +: 2]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        ADR_DATA:    bus_rdata[NPINS-1:0]   = level_i;
        ADR_CFG_LO:  bus_rdata[LO_CW-1:0]   = cfg_lo_q;
        ADR_CFG_HI:  bus_rdata[HI_CW-1:0]   = cfg_hi_q;
        ADR_IE:      bus_rdata[NPINS-1:0]   = ie_q;
        ADR_PEND:    bus_rdata[NPINS-1:0]   = pend_q;
        ADR_EDGE_LO: bus_rdata[LO_PINS-1:0] = edge_lo_q;
        ADR_EDGE_HI: bus_rdata[HI_PINS-1:0] = edge_hi_q;
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = pend_q;

  // R6 R10
  pend_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R9
  pend_no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R7
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 7,
  parameter int LO_PINS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pu,
  output logic             irq_n
);

  logic [NPINS-1:0]      level, rise, fall, latch, pend;
  pin_mode_e [NPINS-1:0] mode;

  gpio_port_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  gpio_port_regs #(.NPINS(NPINS), .LO_PINS(LO_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .level_i(level), .rise_i(rise), .fall_i(fall),
    .mode_o(mode), .latch_o(latch), .pend_o(pend)
  );

  gpio_port_pads #(.NPINS(NPINS)) u_pads (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .latch_i(latch),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  assign irq_n = ~|pend;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0 && irq_n));

endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;

  localparam int NP = 7;
  localparam int LO = 4;
  localparam int ST = 2;
  localparam int MASK = (1 << NP) - 1;

  localparam logic [7:0] A_DATA = 8'hE4, A_CHI = 8'hE5, A_CLO = 8'hE6,
    A_IE = 8'hEC, A_EHI = 8'hED, A_ELO = 8'hEE, A_PEND = 8'hD6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out, pad_pu;
  logic irq_n;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_port #(.NPINS(NP), .LO_PINS(LO), .SYNC_STAGES(ST)) u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_clo, m_chi, m_elo, m_ehi, m_ie, m_pend, m_dout;
  int hist[$];

  always @(posedge clk) begin : model
    int lvl, prv, esel, ev, p;
    if (!rst_n) begin
      m_clo = 0; m_chi = 0; m_elo = 0; m_ehi = 0;
      m_ie = 0; m_pend = 0; m_dout = 0;
      hist.delete();
      for (int k = 0; k <= ST; k++) hist.push_back(0);
    end else begin
      lvl  = hist[ST-1];
      prv  = hist[ST];
      esel = m_elo | (m_ehi << LO);
      ev   = m_ie & ((esel & lvl & ~prv) | (~esel & ~lvl & prv)) & MASK;
      p = m_pend;
      if (bus_sel && bus_wr && bus_addr == A_PEND) p = p & int'(bus_wdata);
      m_pend = (p | ev) & MASK;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          A_CLO:  m_clo  = int'(bus_wdata);
          A_CHI:  m_chi  = int'(bus_wdata) & 8'h3F;
          A_ELO:  m_elo  = int'(bus_wdata) & 8'h0F;
          A_EHI:  m_ehi  = int'(bus_wdata) & 8'h07;
          A_IE:   m_ie   = int'(bus_wdata) & MASK;
          A_DATA: m_dout = int'(bus_wdata) & MASK;
          default: ;
        endcase
      end
      hist.push_front(int'(pad_in));
      void'(hist.pop_back());
    end
  end

  function automatic int exp_read(input logic [7:0] a);
    case (a)
      A_DATA: return hist[ST-1];
      A_CLO:  return m_clo;
      A_CHI:  return m_chi;
      A_ELO:  return m_elo;
      A_EHI:  return m_ehi;
      A_IE:   return m_ie;
      A_PEND: return m_pend;
      default: return 0;
    endcase
  endfunction

  // compare pad controls and request line every cycle
  always @(negedge clk) begin : cmp
    int eoe, eout, epu, md, lb;
    if (rst_n && hist.size() == ST + 1) begin
      eoe = 0; eout = 0; epu = 0;
      for (int i = 0; i < NP; i++) begin
        md = (i < LO) ? ((m_clo >> (2*i)) & 3) : ((m_chi >> (2*(i-LO))) & 3);
        lb = (m_dout >> i) & 1;
        case (md)
          1: epu |= (1 << i);
          2: begin eoe |= (1 << i); eout |= (lb << i); end
          3: if (lb == 0) eoe |= (1 << i);
          default: ;
        endcase
      end
      chk("R3 pad_oe", 32'(pad_oe), eoe);
      chk("R4 pad_out", 32'(pad_out), eout);
      chk("R3 pad_pu", 32'(pad_pu), epu);
      chk("R8 irq_n", 32'(irq_n), (m_pend == 0) ? 1 : 0);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic read_const(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, 32'(bus_rdata), 32'(exp));
    chk({tag, " model"}, 32'(bus_rdata), exp_read(a));
    bus_sel = 1'b0;
  endtask

  task automatic set_pads(input logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_pu", 32'(pad_pu), 0);
    chk("R1 irq_n", 32'(irq_n), 1);
    read_const(A_CLO, 8'h00, "R1 cfg_lo");
    read_const(A_CHI, 8'h00, "R1 cfg_hi");
    read_const(A_IE, 8'h00, "R1 ie");
    read_const(A_PEND, 8'h00, "R1 pend");
    read_const(A_ELO, 8'h00, "R1 edge_lo");

    // R3 R4 modes: pin0 in, pin1 pull-up, pin2 push-pull, pin3..6 open-drain
    bus_write(A_CLO, 8'hE4);
    bus_write(A_CHI, 8'hFF);
    bus_write(A_DATA, 8'h55);
    @(negedge clk);
    chk("R3 mix oe", 32'(pad_oe), 32'h2C);
    chk("R4 mix out", 32'(pad_out), 32'h04);
    chk("R3 mix pu", 32'(pad_pu), 32'h02);
    read_const(A_CHI, 8'h3F, "R2 cfg_hi unused bits");
    bus_write(A_DATA, 8'h00);
    @(negedge clk);
    chk("R4 open-drain low oe", 32'(pad_oe), 32'h7C);
    chk("R4 open-drain low out", 32'(pad_out), 32'h00);

    // R5 readback latency
    set_pads(7'h2A);
    read_const(A_DATA, 8'h00, "R5 one edge");
    read_const(A_DATA, 8'h2A, "R5 two edges");

    // R6 edge selection with enable set
    bus_write(A_ELO, 8'h05);
    bus_write(A_EHI, 8'h02);
    bus_write(A_IE, 8'h7F);
    read_const(A_PEND, 8'h00, "R7 earlier edges while disabled");
    set_pads(7'h55);
    read_const(A_PEND, 8'h00, "R6 after edge 1");
    read_const(A_PEND, 8'h00, "R6 after edge 2");
    read_const(A_PEND, 8'h0F, "R6 after edge 3");
    chk("R8 irq low", 32'(irq_n), 0);

    // R9 clear by zero, ones ignored
    bus_write(A_PEND, 8'h0E);
    read_const(A_PEND, 8'h0E, "R9 clear bit0");
    bus_write(A_PEND, 8'hFF);
    read_const(A_PEND, 8'h0E, "R9 ones ignored");

    // R10 set and clear on the same edge
    set_pads(7'h5D);
    repeat (4) @(negedge clk);
    read_const(A_PEND, 8'h0E, "R6 wrong edge ignored");
    set_pads(7'h55);
    @(negedge clk);
    bus_write(A_PEND, 8'h00);
    read_const(A_PEND, 8'h08, "R10 set wins");
    chk("R8 irq still low", 32'(irq_n), 0);

    // R7 disabled pins never pend
    bus_write(A_IE, 8'h00);
    bus_write(A_PEND, 8'h00);
    @(negedge clk);
    chk("R8 irq released", 32'(irq_n), 1);
    set_pads(7'h2A);
    repeat (4) @(negedge clk);
    set_pads(7'h55);
    repeat (4) @(negedge clk);
    read_const(A_PEND, 8'h00, "R7 disabled");

    // R2 map details
    bus_write(A_EHI, 8'hFF);
    bus_write(A_ELO, 8'hFF);
    read_const(A_EHI, 8'h07, "R2 edge_hi width");
    read_const(A_ELO, 8'h0F, "R2 edge_lo width");
    bus_write(A_IE, 8'hFF);
    read_const(A_IE, 8'h7F, "R2 ie bit7");
    read_const(8'h00, 8'h00, "R2 unmapped");
    read_const(A_DATA, 8'h55, "R5 data levels");
    @(negedge clk);
    bus_addr = A_IE; bus_sel = 1'b0; #1;
    chk("R2 no select", 32'(bus_rdata), 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule